// File: doc/BRIEF.md
# Lane-Masked Load Return Extender

This block sits between the local-memory return path and the vector register file. A returned operation brings its packed element data and control fields: the operation kind, the memory element type, the register width (32 or 64 bits), the number of destination registers and a per-lane execution mask. Once `start` is accepted, the block walks the destination registers one per cycle. For each register it takes one element per lane, widens or converts that element to the register width, and raises a write strobe for each lane whose mask bit is set.

Integers are zero- or sign-extended according to their signedness. Half and single floats are converted exactly to the register's float format. Zero, subnormal, infinite and NaN inputs are all covered, and a NaN keeps its payload because the mantissa is shifted left into the wider field. Stores and atomics that return nothing produce no register writes. An element type that is not legal for the chosen register width raises an error flag instead of writing.

Top module: `lrx_load_return`

## Requirements
- R1: Unsigned element types are zero-extended to the register width. The codes are u8=0, u16=1, u32=2 and u64=3.
- R2: Signed element types are sign-extended to the register width. The codes are s8=4, s16=5, s32=6 and s64=7.
- R3: Floating element types are f16=8, f32=9 and f64=10. With a 64-bit register, f16 and f32 are converted exactly to double. With a 32-bit register, f16 is converted to single and f32 passes through. Zero, subnormal, infinity and NaN are all handled, and a NaN keeps its mantissa payload shifted left.
- R4: For a writeback operation, codes 3, 7 and 10 with a 32-bit register are an error. Codes 11 to 15 are an error at any width. An error makes no register write and raises `err` together with `done`.
- R5: Register k, lane i takes element slot k*LANES+i of `elem_data`. A slot is 64 bits wide, the element sits in its low bits, and the bits above the element are ignored.
- R6: Registers are presented one per cycle in ascending order, starting at index 0 in the cycle after `start` is accepted. During a register's cycle `wr_valid` is high and `wr_lane_en` equals the captured mask. `wr_lane_en` is zero whenever `wr_valid` is low.
- R7: The operation kinds are load=0, returning atomic=1, store=2 and non-returning atomic=3. Kinds 2 and 3 make no writes, and `done` follows in the cycle after acceptance.
- R8: `done` is a one-cycle pulse in the cycle after the last register. `err` is only ever high together with `done`.
- R9: With a 32-bit register (`reg_wide`=0), bits 63:32 of every lane's `wr_data` are zero.
- R10: `start` is accepted only while `ready` is high. A `start` seen during an operation is ignored and does not change the registers, data or strobes in flight.
- R11: A register count of zero on a writeback operation makes no writes and pulses `done` without `err`.
- R12: After reset, `ready` is high and `wr_valid`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when ready) |
| op_kind | input | 2 | Operation kind code |
| elem_type | input | 4 | Memory element type code |
| reg_wide | input | 1 | 1 = 64-bit registers, 0 = 32-bit |
| reg_count | input | CNT_W | Number of destination registers |
| exec_mask | input | LANES | Per-lane execution mask |
| elem_data | input | MAX_REGS*LANES*64 | Element slots, 64 bits each |
| ready | output | 1 | Idle and able to accept start |
| wr_valid | output | 1 | A register write is presented |
| wr_reg | output | IDX_W | Index of the register presented |
| wr_lane_en | output | LANES | Per-lane write strobes |
| wr_data | output | LANES*64 | Formatted per-lane values |
| done | output | 1 | Operation finished pulse |
| err | output | 1 | Illegal type/width pairing, with done |

## Verification
The assertions check the ordering on every cycle. The register index steps by one and starts at zero. Strobes are quiet outside write cycles and hold steady across an operation. `done` lasts one cycle and `err` appears only with it. An error ends without a preceding write, the last index matches the count, and the upper halves stay clear for 32-bit registers. Only the bench scenarios can show that the values are right. They cover the extension of each integer type, the float conversion of special and subnormal values, the slot addressing with garbage in the upper slot bits, the operations that make no writes, and that a start pulse during an operation is ignored.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  typedef enum logic [3:0] {
    ET_U8 = 4'd0, ET_U16 = 4'd1, ET_U32 = 4'd2, ET_U64 = 4'd3,
    ET_S8 = 4'd4, ET_S16 = 4'd5, ET_S32 = 4'd6, ET_S64 = 4'd7,
    ET_F16 = 4'd8, ET_F32 = 4'd9, ET_F64 = 4'd10
  } elem_t;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0, OP_ATOM_RET = 2'd1, OP_STORE = 2'd2, OP_ATOM_NORET = 2'd3
  } op_t;

  function automatic logic writes_back(input logic [1:0] op);
    return (op == OP_LOAD) || (op == OP_ATOM_RET);
  endfunction

  function automatic logic pair_legal(input logic [3:0] t, input logic wide);
    if (t > 4'd10) return 1'b0;
    if (!wide && (t == ET_U64 || t == ET_S64 || t == ET_F64)) return 1'b0;
    return 1'b1;
  endfunction

  // half -> single, exact; subnormals normalised, NaN payload shifted up
  function automatic logic [31:0] half_to_single(input logic [15:0] h);
    logic       s;
    logic [4:0] e;
    logic [9:0] m;
    logic [9:0] mn;
    int         p;
    s = h[15]; e = h[14:10]; m = h[9:0];
    p = 0;
    for (int b = 0; b < 10; b++) if (m[b]) p = b;
    mn = 10'(m << (10 - p));
    if (e == 5'd0 && m == 10'd0) return {s, 31'd0};
    if (e == 5'd0)               return {s, 8'(p + 103), mn, 13'd0};
    if (e == 5'd31)              return {s, 8'hff, m, 13'd0};
    return {s, 8'({3'd0, e} + 8'd112), m, 13'd0};
  endfunction

  // single -> double, exact
  function automatic logic [63:0] single_to_double(input logic [31:0] f);
    logic        s;
    logic [7:0]  e;
    logic [22:0] m;
    logic [22:0] mn;
    int          p;
    s = f[31]; e = f[30:23]; m = f[22:0];
    p = 0;
    for (int b = 0; b < 23; b++) if (m[b]) p = b;
    mn = 23'(m << (23 - p));
    if (e == 8'd0 && m == 23'd0) return {s, 63'd0};
    if (e == 8'd0)               return {s, 11'(p + 874), mn, 29'd0};
    if (e == 8'hff)              return {s, 11'h7ff, m, 29'd0};
    return {s, 11'({3'd0, e} + 11'd896), m, 29'd0};
  endfunction

  function automatic logic [63:0] widen_int(input logic [63:0] v, input int bits,
                                            input logic sgn);
    logic [63:0] r;
    for (int b = 0; b < 64; b++)
      r[b] = (b < bits) ? v[b] : (sgn & v[bits-1]);
    return r;
  endfunction

endpackage

// File: rtl/lrx_lane_fmt.sv
module lrx_lane_fmt
  import lrx_pkg::*;
(
  input  logic [63:0] slot,
  input  logic [3:0]  etype,
  input  logic        wide,
  output logic [63:0] value
);
  logic [63:0] full;

  always_comb begin
    case (etype)
      ET_U8:   full = widen_int(slot, 8, 1'b0);
      ET_U16:  full = widen_int(slot, 16, 1'b0);
      ET_U32:  full = widen_int(slot, 32, 1'b0);
      ET_S8:   full = widen_int(slot, 8, 1'b1);
      ET_S16:  full = widen_int(slot, 16, 1'b1);
      ET_S32:  full = widen_int(slot, 32, 1'b1);
      ET_F16:  full = wide ? single_to_double(half_to_single(slot[15:0]))
                           : {32'd0, half_to_single(slot[15:0])};
      ET_F32:  full = wide ? single_to_double(slot[31:0]) : {32'd0, slot[31:0]};
      default: full = slot;
    endcase
    value = wide ? full : {32'd0, full[31:0]};
  end
endmodule

// File: rtl/lrx_seq.sv
module lrx_seq #(
  parameter int MAX_REGS = 4,
  parameter int CNT_W    = 3,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wb,
  input  logic             legal,
  input  logic [CNT_W-1:0] cnt,
  output logic             ready,
  output logic             accept,
  output logic             run,
  output logic [IDX_W-1:0] idx,
  output logic             fin,
  output logic             fail
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t             st;
  logic [CNT_W-1:0] cnt_q;
  logic             fail_q;
  logic             last;

  assign ready  = (st == S_IDLE);
  assign accept = start && ready;
  assign run    = (st == S_RUN);
  assign fin    = (st == S_FIN);
  assign fail   = fin && fail_q;
  assign last   = (CNT_W'(idx) == cnt_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          idx    <= '0;
          cnt_q  <= cnt;
          fail_q <= wb && !legal;
          st     <= (wb && legal && cnt != '0) ? S_RUN : S_FIN;
        end
        S_RUN: if (last) st <= S_FIN;
               else      idx <= idx + IDX_W'(1);
        default: begin
          st     <= S_IDLE;
          fail_q <= 1'b0;
        end
      endcase
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> idx == $past(idx) + IDX_W'(1));
  p_idx_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept) && run |-> idx == '0);
  p_last_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin && !fail && $past(run) |-> CNT_W'($past(idx)) == cnt_q - CNT_W'(1));
  p_err_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !$past(run));
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run && start |=> (run || fin) && $stable(cnt_q));
endmodule

// File: rtl/lrx_load_return.sv
module lrx_load_return
  import lrx_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int MAX_REGS = 4,
  localparam int CNT_W   = $clog2(MAX_REGS + 1),
  localparam int IDX_W   = (MAX_REGS > 1) ? $clog2(MAX_REGS) : 1,
  localparam int SLOTS   = MAX_REGS * LANES
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            op_kind,
  input  logic [3:0]            elem_type,
  input  logic                  reg_wide,
  input  logic [CNT_W-1:0]      reg_count,
  input  logic [LANES-1:0]      exec_mask,
  input  logic [SLOTS*64-1:0]   elem_data,
  output logic                  ready,
  output logic                  wr_valid,
  output logic [IDX_W-1:0]      wr_reg,
  output logic [LANES-1:0]      wr_lane_en,
  output logic [LANES*64-1:0]   wr_data,
  output logic                  done,
  output logic                  err
);
  logic                accept;
  logic                run;
  logic [IDX_W-1:0]    idx;
  logic [3:0]          type_q;
  logic                wide_q;
  logic [LANES-1:0]    mask_q;
  logic [SLOTS*64-1:0] data_q;
  logic                upper_any;

  lrx_seq #(.MAX_REGS(MAX_REGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .wb(writes_back(op_kind)), .legal(pair_legal(elem_type, reg_wide)),
    .cnt(reg_count), .ready(ready), .accept(accept), .run(run),
    .idx(idx), .fin(done), .fail(err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      wide_q <= 1'b0;
      mask_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      type_q <= elem_type;
      wide_q <= reg_wide;
      mask_q <= exec_mask;
      data_q <= elem_data;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [63:0] slot;
    assign slot = data_q[(int'(idx) * LANES + i) * 64 +: 64];
    lrx_lane_fmt u_fmt (
      .slot(slot), .etype(type_q), .wide(wide_q),
      .value(wr_data[i*64 +: 64])
    );
  end

  assign wr_valid   = run;
  assign wr_reg     = idx;
  assign wr_lane_en = run ? mask_q : '0;

  always_comb begin
    upper_any = 1'b0;
    for (int i = 0; i < LANES; i++) upper_any = upper_any | (|wr_data[i*64+32 +: 32]);
  end

  p_strobe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> wr_lane_en == '0);
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wide_q |-> !upper_any);
  p_mask_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |-> $stable(wr_lane_en));
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

// File: tb/lrx_load_return_tb.sv
module lrx_load_return_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int MAX_REGS = 4;
  localparam int CNT_W = $clog2(MAX_REGS + 1);
  localparam int IDX_W = $clog2(MAX_REGS);
  localparam int SLOTS = MAX_REGS * LANES;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op_kind = '0;
  logic [3:0] elem_type = '0;
  logic reg_wide = 1'b0;
  logic [CNT_W-1:0] reg_count = '0;
  logic [LANES-1:0] exec_mask = '0;
  logic [SLOTS*64-1:0] elem_data = '0;
  logic ready, wr_valid, done, err;
  logic [IDX_W-1:0] wr_reg;
  logic [LANES-1:0] wr_lane_en;
  logic [LANES*64-1:0] wr_data;

  logic [63:0] slots [SLOTS];
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrx_load_return #(.LANES(LANES), .MAX_REGS(MAX_REGS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .elem_type(elem_type), .reg_wide(reg_wide), .reg_count(reg_count),
    .exec_mask(exec_mask), .elem_data(elem_data), .ready(ready),
    .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_lane_en(wr_lane_en),
    .wr_data(wr_data), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] h2d(input logic [15:0] h);
    logic [9:0] m = h[9:0];
    int e = int'(h[14:10]);
    int sh = 0;
    if (e == 0 && m == 0) return {h[15], 63'd0};
    if (e == 31) return {h[15], 11'h7ff, m, 42'd0};
    if (e == 0) begin
      logic [10:0] w = {1'b0, m};
      while (!w[10]) begin w = w << 1; sh++; end
      return {h[15], 11'(1009 - sh), w[9:0], 42'd0};
    end
    return {h[15], 11'(e + 1008), m, 42'd0};
  endfunction

  function automatic logic [63:0] s2d(input logic [31:0] f);
    logic [22:0] m = f[22:0];
    int e = int'(f[30:23]);
    int sh = 0;
    if (e == 0 && m == 0) return {f[31], 63'd0};
    if (e == 255) return {f[31], 11'h7ff, m, 29'd0};
    if (e == 0) begin
      logic [23:0] w = {1'b0, m};
      while (!w[23]) begin w = w << 1; sh++; end
      return {f[31], 11'(897 - sh), w[22:0], 29'd0};
    end
    return {f[31], 11'(e + 896), m, 29'd0};
  endfunction

  function automatic logic [31:0] d2s(input logic [63:0] d);
    int e = int'(d[62:52]);
    if (e == 0) return {d[63], 31'd0};
    if (e == 2047) return {d[63], 8'hff, d[51:29]};
    return {d[63], 8'(e - 896), d[51:29]};
  endfunction

  function automatic logic [63:0] model(input logic [63:0] raw, input int t, input bit wide);
    logic [63:0] r;
    case (t)
      0: r = {56'd0, raw[7:0]};
      1: r = {48'd0, raw[15:0]};
      2: r = {32'd0, raw[31:0]};
      4: r = {{56{raw[7]}}, raw[7:0]};
      5: r = {{48{raw[15]}}, raw[15:0]};
      6: r = {{32{raw[31]}}, raw[31:0]};
      8: r = wide ? h2d(raw[15:0]) : {32'd0, d2s(h2d(raw[15:0]))};
      9: r = wide ? s2d(raw[31:0]) : {32'd0, raw[31:0]};
      default: r = raw;
    endcase
    if (!wide) r[63:32] = '0;
    return r;
  endfunction

  function automatic string type_req(input int t);
    if (t < 4) return "R1";
    if (t < 8) return "R2";
    return "R3";
  endfunction

  task automatic fill_random();
    for (int s = 0; s < SLOTS; s++) slots[s] = {$urandom, $urandom};
  endtask

  task automatic run_op(input int op, input int t, input bit wide, input int cnt,
                        input logic [LANES-1:0] mask, input bit poke);
    bit wb = (op < 2);
    bit legal = (t <= 10) && (wide || !(t == 3 || t == 7 || t == 10));
    int exp_n = (wb && legal) ? cnt : 0;
    bit exp_err = wb && !legal;
    @(negedge clk);
    for (int s = 0; s < SLOTS; s++) elem_data[s*64 +: 64] = slots[s];
    op_kind = 2'(op); elem_type = 4'(t); reg_wide = wide;
    reg_count = CNT_W'(cnt); exec_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < exp_n; j++) begin
      check(wr_valid && wr_reg == IDX_W'(j) && wr_lane_en == mask, "R6",
            "register strobe", {wr_valid, 31'(wr_reg), 32'(wr_lane_en)},
            {1'b1, 31'(j), 32'(mask)});
      begin
        bit ok = 1'b1;
        logic [63:0] a = '0, e = '0;
        for (int i = 0; i < LANES; i++) begin
          logic [63:0] ev = model(slots[j*LANES + i], t, wide);  // R5 slot k*LANES+i
          if (mask[i] && wr_data[i*64 +: 64] !== ev && ok) begin
            ok = 1'b0; a = wr_data[i*64 +: 64]; e = ev;
          end
        end
        check(ok, wide ? type_req(t) : "R9", "lane value", a, e);
      end
      if (poke && j == 0 && exp_n >= 2) begin
        check(!ready, "R10", "ready during run", 64'(ready), 64'd0);
        start = 1'b1; op_kind = 2'd2; exec_mask = ~mask; reg_count = '0;
      end
      if (j == 1) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !wr_valid && err == exp_err,
          exp_err ? "R4" : (!wb ? "R7" : (cnt == 0 ? "R11" : "R8")),
          "done/err", {62'd0, done, err}, {62'd1, 1'b1, exp_err});
    @(negedge clk);
    check(!done && !err && ready, "R8", "done pulse ends", {61'd0, done, err, ready},
          64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ready && !wr_valid && !done && !err, "R12", "reset state",
          {60'd0, ready, wr_valid, done, err}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !wr_valid && !done && !err, "R12", "after reset",
          {60'd0, ready, wr_valid, done, err}, 64'h8);

    // R3 half specials, 64-bit and 32-bit registers
    fill_random();
    slots[0][15:0] = 16'h0000; slots[1][15:0] = 16'h8000; slots[2][15:0] = 16'h0001;
    slots[3][15:0] = 16'h03ff; slots[4][15:0] = 16'h7c00; slots[5][15:0] = 16'hfc00;
    slots[6][15:0] = 16'h7e01; slots[7][15:0] = 16'h3c00;
    run_op(0, 8, 1'b1, 1, 8'hff, 1'b0);
    run_op(1, 8, 1'b0, 1, 8'hff, 1'b0);
    // R3 single specials
    slots[0][31:0] = 32'h00000001; slots[1][31:0] = 32'h007fffff;
    slots[2][31:0] = 32'h7f800000; slots[3][31:0] = 32'h7fc00001;
    slots[4][31:0] = 32'h80000000; slots[5][31:0] = 32'h3f800000;
    slots[6][31:0] = 32'h80400000; slots[7][31:0] = 32'hff800000;
    run_op(0, 9, 1'b1, 1, 8'hff, 1'b0);
    // R2 negative sign extension to both widths
    for (int s = 0; s < SLOTS; s++) slots[s][31:0] = 32'h8080_8080;
    run_op(0, 4, 1'b1, 4, 8'hff, 1'b0);
    run_op(0, 5, 1'b0, 4, 8'ha5, 1'b0);
    run_op(0, 1, 1'b1, 2, 8'h3c, 1'b0);   // R1
    run_op(0, 3, 1'b0, 2, 8'hff, 1'b0);   // R4 u64 on 32-bit
    run_op(0, 12, 1'b1, 2, 8'hff, 1'b0);  // R4 bad code
    run_op(2, 3, 1'b0, 3, 8'hff, 1'b0);   // R7 store
    run_op(3, 2, 1'b1, 3, 8'hff, 1'b0);   // R7 non-returning atomic
    run_op(0, 2, 1'b1, 0, 8'hff, 1'b0);   // R11
    run_op(0, 6, 1'b1, 3, 8'h00, 1'b0);   // R6 empty mask
    fill_random();
    run_op(0, 9, 1'b1, 4, 8'h5a, 1'b1);   // R10 start during run

    for (int n = 0; n < 400; n++) begin
      int r = int'($urandom % 8);
      int op = (r < 6) ? (r % 2) : 2 + (r % 2);
      logic [LANES-1:0] m = LANES'($urandom);
      if (n % 13 == 0) m = '1;
      fill_random();
      run_op(op, int'($urandom % 12), 1'($urandom), int'($urandom % (MAX_REGS + 1)),
             m, (n % 7) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule